// File: doc/BRIEF.md
# MACsec Inline Cipher Beat Framer

This block sits in front of an inline AES/SM4 GCM engine that runs a MACsec-style profile. It turns per-packet descriptors and a byte-counted payload stream into 512-bit stream beats with the sideband fields the engine expects.

A descriptor carries a channel number, a port number, the operation (encrypt or decrypt), the algorithm (AES or SM4), a 96-bit IV and one 32-bit AAD field. The framer emits an IV beat for each packet and forwards the payload as data beats. When the last payload beat of one packet leaves at least one whole 128-bit word free, the framer closes that packet and opens the next one in the same beat.

Key programming requests for numbered key slots are sent as standalone key beats, and only between packets. The cipher itself is not part of this block.

Top module: `macsec_beat_framer`

## Requirements
- R1: After reset `m_valid` is low, `desc_ready` and `key_ready` are high while no key request is pending, and `pay_ready` is low.
- R2: Every emitted beat carries `m_pattern` = 3'b010. A non-key beat never carries the reserved qualifier {`m_data_en`,`m_iv_en`} = 00.
- R3: A descriptor accepted between packets produces a beat with qualifier 01. On that beat `m_keep` covers only bytes 0..15, `m_data[95:0]` is the IV, `m_data[127:96]` is the AAD and the rest of the data is zero. `m_tid[15:0]` is {port, channel} with the channel in bits [9:0], `m_tid[31:16]` is zero, and `m_sm4`/`m_decrypt` come from the descriptor.
- R4: A payload beat that is not the last one is emitted with qualifier 10, `m_last` low, all 64 keep bits set, the payload data unchanged, and `m_tid[15:0]` set to the current packet's {port, channel}.
- R5: A last payload beat of n bytes (1..64) that is not merged is emitted with qualifier 10, `m_last` high, keep bits 0..n-1 set and bytes n..63 zero, and `m_tid` = {id, id} of the ending packet. The next packet then starts with its own qualifier-01 beat.
- R6: A merge happens when n ≤ 48, a descriptor is waiting and no key request is pending. The merged beat has qualifier 11, `m_last` high, keep bits 0..n-1 set, and the new packet's {AAD, IV} word placed at 128-bit word index ceil(n/16). `m_tid[31:16]` is the ending packet's id, `m_tid[15:0]` is the new packet's id, and `m_sm4`/`m_decrypt` follow the new packet.
- R7: A key beat has `m_key_en` high, `m_data_en`, `m_iv_en` and `m_last` low, and the slot number in `m_tid[9:0]` with the other TID bits zero. A 128-bit key sits in `m_data[127:0]` with the rest zero, and a 256-bit key sits in `m_data[255:0]` with `m_key_wide` high. Key beats never appear while a packet is open.
- R8: A key request with SM4 selected and a 256-bit key is consumed but produces no beat.
- R9: While `m_valid` is high and `m_ready` is low, all outputs hold their values.
- R10: A pending key request takes priority over a waiting descriptor between packets. While the key request is pending it also blocks merging, so the packet ends with a plain last beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Descriptor taken on this edge if valid |
| desc_chan | input | 10 | Channel number |
| desc_port | input | 6 | Port number |
| desc_sm4 | input | 1 | 1 selects SM4, 0 selects AES |
| desc_decrypt | input | 1 | 1 selects decrypt, 0 selects encrypt |
| desc_iv | input | 96 | Packet IV |
| desc_aad | input | 32 | Packet AAD field |
| pay_valid | input | 1 | Payload beat offered |
| pay_ready | output | 1 | Payload beat taken on this edge if valid |
| pay_data | input | 512 | Payload bytes, byte 0 in bits [7:0] |
| pay_bytes | input | 7 | Valid byte count on the last beat (1..64) |
| pay_last | input | 1 | Last payload beat of the packet |
| key_valid | input | 1 | Key request offered |
| key_ready | output | 1 | Key request taken on this edge if valid |
| key_slot | input | 10 | Key slot number |
| key_wide | input | 1 | 1 for a 256-bit key, 0 for a 128-bit key |
| key_sm4 | input | 1 | Key is for SM4 |
| key_value | input | 256 | Key bits |
| m_valid | output | 1 | Output beat valid |
| m_ready | input | 1 | Downstream accepts the beat |
| m_data | output | 512 | Beat data |
| m_keep | output | 64 | Byte enables |
| m_last | output | 1 | A packet ends in this beat |
| m_data_en | output | 1 | Qualifier: beat carries payload |
| m_iv_en | output | 1 | Qualifier: beat carries a new IV word |
| m_key_en | output | 1 | Beat is a key write |
| m_key_wide | output | 1 | Key beat carries a 256-bit key |
| m_sm4 | output | 1 | Algorithm of the beat |
| m_decrypt | output | 1 | Operation of the beat |
| m_pattern | output | 3 | Profile tag, 3'b010 |
| m_tid | output | 32 | {end port, end channel, start port, start channel} |

## Verification
Two events can fall in one beat: the last payload beat of a packet and the IV of the following packet. The bench provokes this by holding the next descriptor valid while the last beat is offered. It sweeps the byte count across 20, 48 and 49 to judge where the IV word lands, the keep bits and the two TID halves, and whether the merge is correctly refused. A second collision sets a key request against a packet end that could merge. The key request must be held back, must block the merge, and must come out before the waiting descriptor.

// File: rtl/mfr_pkg.sv
package mfr_pkg;
    localparam int DATA_W     = 512;
    localparam int WORD_W     = 128;
    localparam int CHAN_W     = 10;
    localparam int PORT_W     = 6;
    localparam int KEY_W      = 256;
    localparam int IV_W       = 96;
    localparam int AAD_W      = 32;
    localparam int NBYTES     = DATA_W / 8;
    localparam int WORD_BYTES = WORD_W / 8;
    localparam int NWORDS     = DATA_W / WORD_W;
    localparam int CNT_W      = $clog2(NBYTES) + 1;
    localparam int WIDX_W     = $clog2(NWORDS) + 1;
    localparam int CTX_W      = PORT_W + CHAN_W;
    localparam int TID_W      = 2 * CTX_W;
    localparam logic [2:0] PATTERN_TAG = 3'b010;

    typedef enum logic {ST_GAP, ST_PKT} fr_state_e;

    typedef struct packed {
        logic [PORT_W-1:0] port;
        logic [CHAN_W-1:0] chan;
        logic              sm4;
        logic              dec;
    } pkt_ctx_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [NBYTES-1:0] keep;
        logic              last;
        logic              den;
        logic              iven;
        logic              keyen;
        logic              keywide;
        logic              sm4;
        logic              dec;
        logic [TID_W-1:0]  tid;
    } beat_t;

    typedef struct packed {
        fr_state_e st;
        logic      ov;
        pkt_ctx_t  cur;
        beat_t     ob;
    } fr_regs_t;
endpackage

// File: rtl/mfr_byte_keep.sv
module mfr_byte_keep #(
    parameter int NB = 64,
    parameter int CW = 7
) (
    input  logic [CW-1:0] count,
    output logic [NB-1:0] keep
);
    for (genvar i = 0; i < NB; i++) begin : g_byte
        assign keep[i] = (CW'(i) < count);
    end
endmodule

// File: rtl/mfr_byte_mask.sv
module mfr_byte_mask #(
    parameter int NB = 64
) (
    input  logic [8*NB-1:0] din,
    input  logic [NB-1:0]   keep,
    output logic [8*NB-1:0] dout
);
    for (genvar i = 0; i < NB; i++) begin : g_byte
        assign dout[8*i +: 8] = keep[i] ? din[8*i +: 8] : 8'h00;
    end
endmodule

// File: rtl/mfr_word_place.sv
module mfr_word_place #(
    parameter int DW = 512,
    parameter int WW = 128,
    parameter int IW = 3
) (
    input  logic [DW-1:0] base,
    input  logic [WW-1:0] word,
    input  logic [IW-1:0] idx,
    input  logic          en,
    output logic [DW-1:0] dout
);
    localparam int NW = DW / WW;
    for (genvar w = 0; w < NW; w++) begin : g_word
        assign dout[WW*w +: WW] = (en && idx == IW'(w)) ? word : base[WW*w +: WW];
    end
endmodule

// File: rtl/macsec_beat_framer.sv
module macsec_beat_framer
    import mfr_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  desc_valid,
    output logic                  desc_ready,
    input  logic [CHAN_W-1:0]     desc_chan,
    input  logic [PORT_W-1:0]     desc_port,
    input  logic                  desc_sm4,
    input  logic                  desc_decrypt,
    input  logic [IV_W-1:0]       desc_iv,
    input  logic [AAD_W-1:0]      desc_aad,
    input  logic                  pay_valid,
    output logic                  pay_ready,
    input  logic [DATA_W-1:0]     pay_data,
    input  logic [CNT_W-1:0]      pay_bytes,
    input  logic                  pay_last,
    input  logic                  key_valid,
    output logic                  key_ready,
    input  logic [CHAN_W-1:0]     key_slot,
    input  logic                  key_wide,
    input  logic                  key_sm4,
    input  logic [KEY_W-1:0]      key_value,
    output logic                  m_valid,
    input  logic                  m_ready,
    output logic [DATA_W-1:0]     m_data,
    output logic [NBYTES-1:0]     m_keep,
    output logic                  m_last,
    output logic                  m_data_en,
    output logic                  m_iv_en,
    output logic                  m_key_en,
    output logic                  m_key_wide,
    output logic                  m_sm4,
    output logic                  m_decrypt,
    output logic [2:0]            m_pattern,
    output logic [TID_W-1:0]      m_tid
);
    localparam int WB_SH = $clog2(WORD_BYTES);
    localparam logic [NBYTES-1:0] IV_KEEP = {{(NBYTES-WORD_BYTES){1'b0}}, {WORD_BYTES{1'b1}}};

    fr_regs_t q, d;

    logic              out_free;
    logic [CNT_W-1:0]  round_up;
    logic [WIDX_W-1:0] words_used;
    logic              fits;
    logic              combine_ok;
    logic [WORD_W-1:0] iv_word;
    logic [NBYTES-1:0] tail_keep;
    logic [DATA_W-1:0] tail_data;
    logic [DATA_W-1:0] combo_data;
    logic [CTX_W-1:0]  new_id;
    logic [CTX_W-1:0]  cur_id;
    pkt_ctx_t          new_ctx;

    assign out_free   = !q.ov || m_ready;
    assign round_up   = pay_bytes + CNT_W'(WORD_BYTES - 1);
    assign words_used = WIDX_W'(round_up >> WB_SH);
    assign fits       = words_used < WIDX_W'(NWORDS);
    assign combine_ok = pay_last && fits && !key_valid;
    assign iv_word    = {desc_aad, desc_iv};
    assign new_id     = {desc_port, desc_chan};
    assign cur_id     = {q.cur.port, q.cur.chan};
    assign new_ctx    = '{port: desc_port, chan: desc_chan, sm4: desc_sm4, dec: desc_decrypt};

    mfr_byte_keep #(.NB(NBYTES), .CW(CNT_W)) u_keep (
        .count (pay_bytes),
        .keep  (tail_keep)
    );

    mfr_byte_mask #(.NB(NBYTES)) u_mask (
        .din  (pay_data),
        .keep (tail_keep),
        .dout (tail_data)
    );

    mfr_word_place #(.DW(DATA_W), .WW(WORD_W), .IW(WIDX_W)) u_place (
        .base (tail_data),
        .word (iv_word),
        .idx  (words_used),
        .en   (combine_ok),
        .dout (combo_data)
    );

    assign pay_ready  = (q.st == ST_PKT) && out_free;
    assign key_ready  = (q.st == ST_GAP) && out_free;
    assign desc_ready = (q.st == ST_PKT) ? (out_free && pay_valid && combine_ok)
                                         : (out_free && !key_valid);

    always_comb begin
        beat_t b;
        d = q;
        b = '0;
        if (q.ov && m_ready) d.ov = 1'b0;
        case (q.st)
            ST_GAP: begin
                if (out_free && key_valid) begin
                    b.keyen   = 1'b1;
                    b.keywide = key_wide;
                    b.sm4     = key_sm4;
                    b.tid     = TID_W'(key_slot);
                    b.data    = key_wide ? DATA_W'(key_value)
                                         : DATA_W'(key_value[KEY_W/2-1:0]);
                    if (!(key_sm4 && key_wide)) begin
                        d.ov = 1'b1;
                        d.ob = b;
                    end
                end else if (out_free && desc_valid) begin
                    b.iven = 1'b1;
                    b.sm4  = desc_sm4;
                    b.dec  = desc_decrypt;
                    b.keep = IV_KEEP;
                    b.data = DATA_W'(iv_word);
                    b.tid  = {{CTX_W{1'b0}}, new_id};
                    d.ov   = 1'b1;
                    d.ob   = b;
                    d.cur  = new_ctx;
                    d.st   = ST_PKT;
                end
            end
            default: begin
                if (out_free && pay_valid) begin
                    b.den = 1'b1;
                    b.sm4 = q.cur.sm4;
                    b.dec = q.cur.dec;
                    if (!pay_last) begin
                        b.keep = '1;
                        b.data = pay_data;
                        b.tid  = {{CTX_W{1'b0}}, cur_id};
                    end else if (combine_ok && desc_valid) begin
                        b.iven = 1'b1;
                        b.last = 1'b1;
                        b.keep = tail_keep;
                        b.data = combo_data;
                        b.sm4  = desc_sm4;
                        b.dec  = desc_decrypt;
                        b.tid  = {cur_id, new_id};
                        d.cur  = new_ctx;
                    end else begin
                        b.last = 1'b1;
                        b.keep = tail_keep;
                        b.data = tail_data;
                        b.tid  = {cur_id, cur_id};
                        d.st   = ST_GAP;
                    end
                    d.ov = 1'b1;
                    d.ob = b;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign m_valid    = q.ov;
    assign m_data     = q.ob.data;
    assign m_keep     = q.ob.keep;
    assign m_last     = q.ob.last;
    assign m_data_en  = q.ob.den;
    assign m_iv_en    = q.ob.iven;
    assign m_key_en   = q.ob.keyen;
    assign m_key_wide = q.ob.keywide;
    assign m_sm4      = q.ob.sm4;
    assign m_decrypt  = q.ob.dec;
    assign m_tid      = q.ob.tid;
    assign m_pattern  = q.ov ? PATTERN_TAG : 3'b000;
endmodule

// File: rtl/macsec_beat_framer_chk.sv
module macsec_beat_framer_chk
    import mfr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              m_valid,
    input logic              m_ready,
    input logic [DATA_W-1:0] m_data,
    input logic [NBYTES-1:0] m_keep,
    input logic              m_last,
    input logic              m_data_en,
    input logic              m_iv_en,
    input logic              m_key_en,
    input logic              m_key_wide,
    input logic              m_sm4,
    input logic [TID_W-1:0]  m_tid
);
    localparam logic [NBYTES-1:0] IV_ONLY_KEEP = {{(NBYTES-WORD_BYTES){1'b0}}, {WORD_BYTES{1'b1}}};

    logic pkt_open;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pkt_open <= 1'b0;
        else if (m_valid && m_ready) begin
            if (m_iv_en)     pkt_open <= 1'b1;
            else if (m_last) pkt_open <= 1'b0;
        end
    end

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid && !m_ready |=> m_valid && $stable(m_data) && $stable(m_keep)
            && $stable({m_last, m_data_en, m_iv_en, m_key_en, m_key_wide, m_sm4, m_tid})); // R9

    AST_NO_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid && !m_key_en |-> (m_data_en || m_iv_en)); // R2

    AST_IV_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid && m_iv_en && !m_data_en |-> m_keep == IV_ONLY_KEEP && !m_last); // R3

    AST_MERGE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid && m_data_en && m_iv_en |-> m_last); // R6

    AST_KEY_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid && m_key_en |-> !m_data_en && !m_iv_en && !m_last); // R7

    AST_KEY_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid && m_key_en |-> !pkt_open); // R7

    AST_SM4_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid && m_key_en && m_sm4 |-> !m_key_wide); // R8
endmodule

bind macsec_beat_framer macsec_beat_framer_chk u_chk (.*);

// File: tb/macsec_beat_framer_test.sv
module macsec_beat_framer_test;
    import mfr_pkg::*;

    typedef struct {
        logic [CHAN_W-1:0] chan;
        logic [PORT_W-1:0] port;
        logic              sm4;
        logic              dec;
        logic [IV_W-1:0]   iv;
        logic [AAD_W-1:0]  aad;
    } tdesc_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic desc_valid = 0, desc_ready, desc_sm4 = 0, desc_decrypt = 0;
    logic [CHAN_W-1:0] desc_chan = '0;
    logic [PORT_W-1:0] desc_port = '0;
    logic [IV_W-1:0] desc_iv = '0;
    logic [AAD_W-1:0] desc_aad = '0;
    logic pay_valid = 0, pay_ready, pay_last = 0;
    logic [DATA_W-1:0] pay_data = '0;
    logic [CNT_W-1:0] pay_bytes = '0;
    logic key_valid = 0, key_ready, key_wide = 0, key_sm4 = 0;
    logic [CHAN_W-1:0] key_slot = '0;
    logic [KEY_W-1:0] key_value = '0;
    logic m_valid, m_ready = 1'b1, m_last, m_data_en, m_iv_en, m_key_en, m_key_wide, m_sm4, m_decrypt;
    logic [DATA_W-1:0] m_data;
    logic [NBYTES-1:0] m_keep;
    logic [2:0] m_pattern;
    logic [TID_W-1:0] m_tid;

    macsec_beat_framer uut (.*);

    int checks = 0;
    int errors = 0;

    localparam int MAXB = 32;
    logic [DATA_W-1:0] r_data [MAXB];
    logic [NBYTES-1:0] r_keep [MAXB];
    logic [TID_W-1:0]  r_tid  [MAXB];
    logic [2:0]        r_pat  [MAXB];
    logic [7:0]        r_flag [MAXB];  // {key, den, iv, last, kw, sm4, dec, 0}
    int nb = 0;

    always begin
        @(negedge clk);
        #9;
        if (rst_n && m_valid && m_ready && nb < MAXB) begin
            r_data[nb] = m_data;
            r_keep[nb] = m_keep;
            r_tid[nb]  = m_tid;
            r_pat[nb]  = m_pattern;
            r_flag[nb] = {m_key_en, m_data_en, m_iv_en, m_last, m_key_wide, m_sm4, m_decrypt, 1'b0};
            nb++;
        end
    end

    task automatic chk(string req, string what, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [DATA_W-1:0] pdata(int seed);
        logic [DATA_W-1:0] v;
        for (int i = 0; i < NBYTES; i++) v[8*i +: 8] = 8'(seed * 29 + i * 7 + 1);
        return v;
    endfunction

    function automatic logic [NBYTES-1:0] kmask(int n);
        logic [NBYTES-1:0] v;
        for (int i = 0; i < NBYTES; i++) v[i] = (i < n);
        return v;
    endfunction

    function automatic logic [DATA_W-1:0] masked(logic [DATA_W-1:0] dv, int n);
        logic [DATA_W-1:0] v;
        for (int i = 0; i < NBYTES; i++) v[8*i +: 8] = (i < n) ? dv[8*i +: 8] : 8'h00;
        return v;
    endfunction

    function automatic logic [CTX_W-1:0] id_of(tdesc_t x);
        return {x.port, x.chan};
    endfunction

    task automatic drive_desc(tdesc_t x);
        bit got = 0;
        desc_valid = 1; desc_chan = x.chan; desc_port = x.port;
        desc_sm4 = x.sm4; desc_decrypt = x.dec; desc_iv = x.iv; desc_aad = x.aad;
        while (!got) begin #9; got = desc_ready; @(negedge clk); end
        desc_valid = 0;
    endtask

    task automatic drive_pay(logic [DATA_W-1:0] dv, int n, logic last);
        bit got = 0;
        pay_valid = 1; pay_data = dv; pay_bytes = CNT_W'(n); pay_last = last;
        while (!got) begin #9; got = pay_ready; @(negedge clk); end
        pay_valid = 0;
    endtask

    task automatic drive_key(int slot, logic wide, logic sm4, logic [KEY_W-1:0] k);
        bit got = 0;
        key_valid = 1; key_slot = CHAN_W'(slot); key_wide = wide; key_sm4 = sm4; key_value = k;
        while (!got) begin #9; got = key_ready; @(negedge clk); end
        key_valid = 0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 0;
        desc_valid = 0; pay_valid = 0; key_valid = 0; m_ready = 1;
        idle(3);
        rst_n = 1;
        nb = 0;
        idle(1);
    endtask

    // flags: key, den, iv, last
    task automatic chk_beat(string req, int i, logic key, logic den, logic iv, logic last,
                            logic [NBYTES-1:0] keep, logic [TID_W-1:0] tid, logic [DATA_W-1:0] dv);
        chk(req, $sformatf("beat%0d qualifiers", i), r_flag[i][7:4], {key, den, iv, last});
        chk(req, $sformatf("beat%0d keep", i), r_keep[i], keep);
        chk(req, $sformatf("beat%0d tid", i), r_tid[i], tid);
        chk(req, $sformatf("beat%0d data", i), r_data[i], dv);
        chk("R2", $sformatf("beat%0d pattern", i), r_pat[i], 3'b010);
    endtask

    function automatic logic [DATA_W-1:0] iv_beat(tdesc_t x);
        return DATA_W'({x.aad, x.iv});
    endfunction

    localparam logic [NBYTES-1:0] K16 = {{(NBYTES-16){1'b0}}, {16{1'b1}}};

    tdesc_t da, db, dc;

    task automatic t_reset();
        do_reset();
        chk("R1", "m_valid", m_valid, 0);
        chk("R1", "desc_ready", desc_ready, 1);
        chk("R1", "key_ready", key_ready, 1);
        chk("R1", "pay_ready", pay_ready, 0);
    endtask

    task automatic t_single();
        do_reset();
        drive_desc(da);
        drive_pay(pdata(1), 64, 0);
        drive_pay(pdata(2), 60, 1);
        idle(4);
        chk("R3", "beat count", nb, 3);
        chk_beat("R3", 0, 0, 0, 1, 0, K16, {16'h0, id_of(da)}, iv_beat(da));
        chk("R3", "iv beat sm4/dec", r_flag[0][2:1], {da.sm4, da.dec});
        chk_beat("R4", 1, 0, 1, 0, 0, '1, {16'h0, id_of(da)}, pdata(1));
        chk_beat("R5", 2, 0, 1, 0, 1, kmask(60), {id_of(da), id_of(da)}, masked(pdata(2), 60));
    endtask

    task automatic t_merge20();
        logic [DATA_W-1:0] e;
        do_reset();
        fork
            begin drive_desc(da); drive_desc(db); end
            begin drive_pay(pdata(3), 20, 1); drive_pay(pdata(4), 64, 1); end
        join
        idle(4);
        chk("R6", "beat count", nb, 3);
        e = masked(pdata(3), 20);
        e[WORD_W*2 +: WORD_W] = {db.aad, db.iv};
        chk_beat("R6", 1, 0, 1, 1, 1, kmask(20), {id_of(da), id_of(db)}, e);
        chk("R6", "merged sm4/dec follow new packet", r_flag[1][2:1], {db.sm4, db.dec});
        chk_beat("R5", 2, 0, 1, 0, 1, '1, {id_of(db), id_of(db)}, pdata(4));
    endtask

    task automatic t_bounds();
        logic [DATA_W-1:0] e;
        do_reset();
        fork
            begin drive_desc(da); drive_desc(db); drive_desc(dc); end
            begin drive_pay(pdata(5), 48, 1); drive_pay(pdata(6), 49, 1); drive_pay(pdata(7), 16, 1); end
        join
        idle(4);
        chk("R6", "beat count", nb, 5);
        e = masked(pdata(5), 48);
        e[WORD_W*3 +: WORD_W] = {db.aad, db.iv};
        chk_beat("R6", 1, 0, 1, 1, 1, kmask(48), {id_of(da), id_of(db)}, e);
        chk_beat("R5", 2, 0, 1, 0, 1, kmask(49), {id_of(db), id_of(db)}, masked(pdata(6), 49));
        chk_beat("R5", 3, 0, 0, 1, 0, K16, {16'h0, id_of(dc)}, iv_beat(dc));
        chk_beat("R5", 4, 0, 1, 0, 1, kmask(16), {id_of(dc), id_of(dc)}, masked(pdata(7), 16));
    endtask

    task automatic t_keys();
        logic [KEY_W-1:0] k1 = {8{32'hC0DE_0001}};
        logic [KEY_W-1:0] k2 = {8{32'h5EED_0002}};
        logic [KEY_W-1:0] k3 = {8{32'hBAD0_0003}};
        logic [KEY_W-1:0] k4 = {8{32'h4D4D_0004}};
        do_reset();
        drive_key(5, 0, 0, k1);
        drive_key(1023, 1, 0, k2);
        drive_key(77, 1, 1, k3);
        drive_key(9, 0, 1, k4);
        idle(4);
        chk("R8", "beat count after dropped key", nb, 3);
        chk_beat("R7", 0, 1, 0, 0, 0, '0, TID_W'(5), DATA_W'(k1[127:0]));
        chk("R7", "narrow key size flag", r_flag[0][3], 0);
        chk_beat("R7", 1, 1, 0, 0, 0, '0, TID_W'(1023), DATA_W'(k2));
        chk("R7", "wide key size flag", r_flag[1][3], 1);
        chk_beat("R8", 2, 1, 0, 0, 0, '0, TID_W'(9), DATA_W'(k4[127:0]));
        chk("R8", "sm4 key flags", r_flag[2][3:2], 2'b01);
    endtask

    task automatic t_key_clash();
        logic [KEY_W-1:0] k = {8{32'hFACE_0012}};
        do_reset();
        fork
            begin drive_desc(da); drive_desc(db); end
            begin idle(2); drive_key(12, 0, 0, k); end
            begin idle(5); drive_pay(pdata(8), 16, 1); drive_pay(pdata(9), 8, 1); end
        join
        idle(4);
        chk("R10", "beat count", nb, 5);
        chk_beat("R10", 1, 0, 1, 0, 1, kmask(16), {id_of(da), id_of(da)}, masked(pdata(8), 16));
        chk_beat("R10", 2, 1, 0, 0, 0, '0, TID_W'(12), DATA_W'(k[127:0]));
        chk_beat("R10", 3, 0, 0, 1, 0, K16, {16'h0, id_of(db)}, iv_beat(db));
        chk_beat("R10", 4, 0, 1, 0, 1, kmask(8), {id_of(db), id_of(db)}, masked(pdata(9), 8));
    endtask

    task automatic t_stall();
        do_reset();
        m_ready = 0;
        fork
            begin drive_desc(dc); end
            begin drive_pay(pdata(10), 64, 0); drive_pay(pdata(11), 30, 1); end
            begin
                logic [DATA_W-1:0] sd;
                logic [TID_W-1:0] st;
                logic sv;
                sv = 0;
                while (!sv) begin @(negedge clk); #9; sv = m_valid; end
                sd = m_data; st = m_tid;
                repeat (3) begin
                    @(negedge clk); #9;
                    chk("R9", "valid held", m_valid, 1);
                    chk("R9", "data held", m_data, sd);
                    chk("R9", "tid held", m_tid, st);
                    chk("R9", "payload stalled", pay_ready, 0);
                end
                @(negedge clk);
                m_ready = 1;
            end
        join
        idle(4);
        chk("R9", "beat count", nb, 3);
        chk_beat("R9", 0, 0, 0, 1, 0, K16, {16'h0, id_of(dc)}, iv_beat(dc));
        chk_beat("R4", 1, 0, 1, 0, 0, '1, {16'h0, id_of(dc)}, pdata(10));
        chk_beat("R9", 2, 0, 1, 0, 1, kmask(30), {id_of(dc), id_of(dc)}, masked(pdata(11), 30));
    endtask

    initial begin
        #(20 * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog run did not finish actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        da = '{chan: 10'd3,   port: 6'd2,  sm4: 1'b0, dec: 1'b0,
               iv: 96'h0A0B0C0D_11121314_21222324, aad: 32'hA0A0_0001};
        db = '{chan: 10'd1000, port: 6'd63, sm4: 1'b1, dec: 1'b1,
               iv: 96'h55667788_99AABBCC_DDEEFF01, aad: 32'hB0B0_0002};
        dc = '{chan: 10'd517,  port: 6'd17, sm4: 1'b0, dec: 1'b1,
               iv: 96'h13579BDF_2468ACE0_0F1E2D3C, aad: 32'hC0C0_0003};
        @(negedge clk);
        t_reset();
        t_single();
        t_merge20();
        t_bounds();
        t_keys();
        t_key_clash();
        t_stall();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule